// File: doc/BRIEF.md
# PCI Segment Speed Mode Selector

This block settles the operating clock mode of a single PCI / PCI-X bus segment. When power-good rises it captures three boot-time settings: a clock-source strap, the hot-plug enable and the single-slot-without-glue hot-plug option. From the captured settings and three live bus-side inputs it resolves a two-bit speed code. The live inputs are the 66 MHz enable line as read back from the pin, the PCI-X capable line and the 133 MHz permit line.

The block also controls the 66 MHz enable pin, which is open-drain in style. The pin is either pulled low or released to an external pull-up. It is pulled low when hot-plug was enabled at power-up. It is also pulled low once software has written the 33 MHz code to the frequency register, and that record is sticky. A captured single-slot-without-glue setting overrides both and always releases the pin. When the block pulls the pin low, the segment reads 33 MHz conventional. The resolved code therefore drops to PCI33 whenever the pin is driven.

All bus-side inputs pass through a synchronizer before use. The register write port is already in the block's clock domain.

Top module: `pcs_speed_sel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `mode` reads 0 (PCI33), `clk_src_sel` reads 0 and `m66_oe` reads 0. Reset is the only thing that clears the sticky 33 MHz write record.
- R2: On each rising edge of the synchronized `pwr_good`, `clk_src_sel` takes the synchronized `strap_in`. A value of 1 selects the 200 MHz differential clock and 0 selects the 66 MHz clock.
- R3: Between rising edges of `pwr_good`, changes on `strap_in`, `hp_en_in` or `hp_noglue_in` have no effect on `clk_src_sel` or `m66_oe`.
- R4: With `pcix_cap_in` low and the pin not driven, `mode` is 1 (PCI66) when `m66_in` is 1 and 0 (PCI33) when it is 0.
- R5: With `pcix_cap_in` high and the pin not driven, `mode` is 3 (PCI-X 133) when `en133_in` is 1 and 2 (PCI-X 100) when it is 0.
- R6: If `hp_en_in` was 1 at the last `pwr_good` rise and single-slot-without-glue was 0, then `m66_oe` is 1 and `mode` is 0 (PCI33), whatever the other inputs are.
- R7: A write (`freq_wr` high) with `freq_wdata` equal to 2'b00 sets a sticky record. From the next cycle that record drives the pin low (`m66_oe` = 1) unless single-slot-without-glue is captured. Later writes of other codes do not clear it.
- R8: With hot-plug not captured and no 2'b00 write since reset, `m66_oe` is 0.
- R9: With single-slot-without-glue captured at the last `pwr_good` rise, `m66_oe` is 0 regardless of hot-plug and the frequency register.
- R10: `m66_do` is 0 on every cycle.
- R11: A change on a live bus input first shows on `mode` after the third rising clock edge. After the second edge the old value is still present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Power-good; rising edge captures boot settings |
| strap_in | input | 1 | Clock-source strap (1 = 200 MHz differential, 0 = 66 MHz) |
| m66_in | input | 1 | 66 MHz enable line as read from the pin |
| pcix_cap_in | input | 1 | All devices on the segment are PCI-X capable |
| en133_in | input | 1 | Permit 133 MHz PCI-X operation |
| hp_en_in | input | 1 | Hot-plug enabled, captured at power-good |
| hp_noglue_in | input | 1 | Single-slot hot-plug without glue, captured at power-good |
| freq_wr | input | 1 | Frequency register write strobe |
| freq_wdata | input | 2 | Frequency register write data |
| mode | output | 2 | Resolved speed: 0 PCI33, 1 PCI66, 2 PCI-X100, 3 PCI-X133 |
| clk_src_sel | output | 1 | Captured clock-source select |
| m66_oe | output | 1 | Drive enable for the 66 MHz enable pin |
| m66_do | output | 1 | Drive value for the 66 MHz enable pin |

## Verification
The embedded properties check several things on every cycle. The pin data stays low and the sticky record never falls outside reset. The captured settings hold between power-good edges. A driven pin forces PCI33 one cycle later, and the no-glue setting always keeps the pin released. Only the bench's scenarios can show the rest. That covers which strap value each power-good edge captures and the four speed codes for each input pattern. It also covers the exact three-edge synchronizer latency and the interplay of hot-plug, no-glue and the write record across successive power-good cycles and a mid-run reset.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [1:0] {
        MODE_PCI33   = 2'd0,
        MODE_PCI66   = 2'd1,
        MODE_PCIX100 = 2'd2,
        MODE_PCIX133 = 2'd3
    } bus_mode_e;

    // bus-side inputs that cross into the clock domain
    typedef struct packed {
        logic pwr_good;
        logic strap;
        logic m66;
        logic pcix_cap;
        logic en133;
        logic hp_en;
        logic hp_noglue;
    } pin_in_t;

    localparam int PIN_IN_W = $bits(pin_in_t);

    // settings captured on the power-good rising edge
    typedef struct packed {
        logic clk_sel;
        logic hp_en;
        logic hp_noglue;
    } boot_cfg_t;

    typedef struct packed {
        logic oe;
        logic dout;
    } pin_drv_t;

    localparam int          FREQ_W    = 2;
    localparam logic [1:0]  FREQ_SLOW = 2'b00;

    function automatic bus_mode_e resolve_mode(
        input logic m66,
        input logic pcix_cap,
        input logic en133,
        input logic pin_low
    );
        bus_mode_e m;
        if (pin_low)       m = MODE_PCI33;
        else if (pcix_cap) m = en133 ? MODE_PCIX133 : MODE_PCIX100;
        else               m = m66 ? MODE_PCI66 : MODE_PCI33;
        return m;
    endfunction

endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= '0;
                    else     chain[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[gi] <= '0;
                    else     chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];

endmodule

// File: rtl/pcs_boot_latch.sv
module pcs_boot_latch
    import pcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pg_s,
    input  boot_cfg_t cfg_in,
    output boot_cfg_t cfg_q,
    output logic      pg_rise
);
    logic pg_d;

    always_ff @(posedge clk) begin
        if (rst) pg_d <= 1'b0;
        else     pg_d <= pg_s;
    end

    assign pg_rise = pg_s & ~pg_d;

    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (pg_rise) cfg_q <= cfg_in;
    end

    // captured settings move only on a power-good rise
    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !pg_rise |=> $stable(cfg_q));

    // on a rise the captured value is the one presented
    p_cfg_take_r2: assert property (@(posedge clk) disable iff (rst)
        pg_rise |=> cfg_q == $past(cfg_in));

endmodule

// File: rtl/pcs_pin_ctrl.sv
module pcs_pin_ctrl
    import pcs_pkg::*;
#(
    parameter int         FW        = FREQ_W,
    parameter logic [1:0] SLOW_CODE = FREQ_SLOW
) (
    input  logic          clk,
    input  logic          rst,
    input  boot_cfg_t     cfg,
    input  logic          wr,
    input  logic [FW-1:0] wdata,
    output pin_drv_t      drv,
    output logic          slow_seen
);
    logic slow_wr;

    assign slow_wr = wr && (wdata == SLOW_CODE[FW-1:0]);

    always_ff @(posedge clk) begin
        if (rst)          slow_seen <= 1'b0;
        else if (slow_wr) slow_seen <= 1'b1;
    end

    always_comb begin
        drv.dout = 1'b0;
        if (cfg.hp_noglue) drv.oe = 1'b0;
        else               drv.oe = cfg.hp_en | slow_seen;
    end

    // the sticky record only falls through reset
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        slow_seen |=> slow_seen);

    // a slow-code write takes effect on the next cycle
    p_slow_wr_r7: assert property (@(posedge clk) disable iff (rst)
        slow_wr |=> slow_seen);

    // pin data is low whenever driven
    p_dout_low_r10: assert property (@(posedge clk) disable iff (rst)
        drv.oe |-> !drv.dout);

endmodule

// File: rtl/pcs_mode_resolve.sv
module pcs_mode_resolve
    import pcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      m66_s,
    input  logic      pcix_s,
    input  logic      en133_s,
    input  logic      pin_low,
    output bus_mode_e mode_q
);
    bus_mode_e mode_d;

    assign mode_d = resolve_mode(m66_s, pcix_s, en133_s, pin_low);

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_PCI33;
        else     mode_q <= mode_d;
    end

    // PCI-X codes only appear when the capable line was high
    p_pcix_code_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PCIX100 || mode_q == MODE_PCIX133) |-> $past(pcix_s));

    // 66 MHz conventional needs the pin read high
    p_pci66_code_r4: assert property (@(posedge clk) disable iff (rst)
        mode_q == MODE_PCI66 |-> $past(m66_s) && !$past(pcix_s));

endmodule

// File: rtl/pcs_speed_sel.sv
module pcs_speed_sel
    import pcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              strap_in,
    input  logic              m66_in,
    input  logic              pcix_cap_in,
    input  logic              en133_in,
    input  logic              hp_en_in,
    input  logic              hp_noglue_in,
    input  logic              freq_wr,
    input  logic [FREQ_W-1:0] freq_wdata,
    output logic [1:0]        mode,
    output logic              clk_src_sel,
    output logic              m66_oe,
    output logic              m66_do
);
    pin_in_t   raw_in;
    pin_in_t   syn_in;
    boot_cfg_t cfg_now;
    boot_cfg_t cfg_q;
    pin_drv_t  drv;
    bus_mode_e mode_q;
    logic      pg_rise;
    logic      slow_seen;

    always_comb begin
        raw_in.pwr_good  = pwr_good;
        raw_in.strap     = strap_in;
        raw_in.m66       = m66_in;
        raw_in.pcix_cap  = pcix_cap_in;
        raw_in.en133     = en133_in;
        raw_in.hp_en     = hp_en_in;
        raw_in.hp_noglue = hp_noglue_in;
    end

    pcs_sync #(.W(PIN_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    always_comb begin
        cfg_now.clk_sel   = syn_in.strap;
        cfg_now.hp_en     = syn_in.hp_en;
        cfg_now.hp_noglue = syn_in.hp_noglue;
    end

    pcs_boot_latch u_boot (
        .clk     (clk),
        .rst     (rst),
        .pg_s    (syn_in.pwr_good),
        .cfg_in  (cfg_now),
        .cfg_q   (cfg_q),
        .pg_rise (pg_rise)
    );

    pcs_pin_ctrl u_pin (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg_q),
        .wr        (freq_wr),
        .wdata     (freq_wdata),
        .drv       (drv),
        .slow_seen (slow_seen)
    );

    pcs_mode_resolve u_mode (
        .clk     (clk),
        .rst     (rst),
        .m66_s   (syn_in.m66),
        .pcix_s  (syn_in.pcix_cap),
        .en133_s (syn_in.en133),
        .pin_low (drv.oe),
        .mode_q  (mode_q)
    );

    assign mode        = mode_q;
    assign clk_src_sel = cfg_q.clk_sel;
    assign m66_oe      = drv.oe;
    assign m66_do      = drv.dout;

    // reset state
    p_reset_r1: assert property (@(posedge clk)
        rst |=> mode == 2'd0 && !clk_src_sel && !m66_oe);

    // driving the pin forces PCI33 on the next cycle
    p_forced_slow_r6: assert property (@(posedge clk) disable iff (rst)
        m66_oe |=> mode == 2'd0);

    // no-glue capture keeps the pin released
    p_noglue_release_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_q.hp_noglue |-> !m66_oe);

    // hot-plug capture without no-glue drives the pin
    p_hp_drive_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.hp_en && !cfg_q.hp_noglue) |-> m66_oe);

    // the pin is released with no hot-plug and no slow write
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.hp_en && !slow_seen) |-> !m66_oe);

    // pin data never high
    p_do_low_r10: assert property (@(posedge clk) !m66_do);

    // clock select only changes right after a power-good rise
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(pg_rise) && !$past(rst) |-> $stable(clk_src_sel));

endmodule

// File: tb/pcs_speed_sel_tb.sv
module pcs_speed_sel_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_good = 1'b0;
    logic       strap_in = 1'b0;
    logic       m66_in = 1'b1;
    logic       pcix_cap_in = 1'b0;
    logic       en133_in = 1'b0;
    logic       hp_en_in = 1'b0;
    logic       hp_noglue_in = 1'b0;
    logic       freq_wr = 1'b0;
    logic [1:0] freq_wdata = 2'b11;
    logic [1:0] mode;
    logic       clk_src_sel;
    logic       m66_oe;
    logic       m66_do;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [1:0] mode;
        logic       sel;
        logic       oe;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    pcs_speed_sel u_dut (
        .clk          (clk),
        .rst          (rst),
        .pwr_good     (pwr_good),
        .strap_in     (strap_in),
        .m66_in       (m66_in),
        .pcix_cap_in  (pcix_cap_in),
        .en133_in     (en133_in),
        .hp_en_in     (hp_en_in),
        .hp_noglue_in (hp_noglue_in),
        .freq_wr      (freq_wr),
        .freq_wdata   (freq_wdata),
        .mode         (mode),
        .clk_src_sel  (clk_src_sel),
        .m66_oe       (m66_oe),
        .m66_do       (m66_do)
    );

    // monitor: compare each queued expectation at the next falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_tests++;
                if (mode !== e.mode || clk_src_sel !== e.sel ||
                    m66_oe !== e.oe || m66_do !== 1'b0) begin
                    n_fail++;
                    $display("FAIL %s: got mode=%0d sel=%0b oe=%0b do=%0b, expected mode=%0d sel=%0b oe=%0b do=0",
                             e.tag, mode, clk_src_sel, m66_oe, m66_do, e.mode, e.sel, e.oe);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_st(input logic [1:0] m, input logic s, input logic o, input string tag);
        exp_t e;
        e.mode = m; e.sel = s; e.oe = o; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drive_bus(input logic m66, input logic pcix, input logic e133);
        @(negedge clk);
        m66_in = m66; pcix_cap_in = pcix; en133_in = e133;
        settle(5);
    endtask

    task automatic pg_cycle(input logic strap, input logic hp, input logic ng);
        @(negedge clk);
        pwr_good = 1'b0;
        settle(4);
        @(negedge clk);
        strap_in = strap; hp_en_in = hp; hp_noglue_in = ng;
        settle(4);
        @(negedge clk);
        pwr_good = 1'b1;
        settle(6);
    endtask

    task automatic reg_write(input logic [1:0] d);
        @(negedge clk);
        freq_wr = 1'b1; freq_wdata = d;
        @(negedge clk);
        freq_wr = 1'b0; freq_wdata = 2'b11;
        settle(3);
    endtask

    initial begin
        // R1: reset state
        settle(3);
        expect_st(2'd0, 1'b0, 1'b0, "R1 reset");
        @(negedge clk); rst = 1'b0;

        // R4 / R8: conventional speeds, pin released
        drive_bus(1'b1, 1'b0, 1'b0);
        expect_st(2'd1, 1'b0, 1'b0, "R4 m66 high gives PCI66 (R8 released)");
        drive_bus(1'b0, 1'b0, 1'b0);
        expect_st(2'd0, 1'b0, 1'b0, "R4 m66 low gives PCI33");

        // R5: PCI-X speeds
        drive_bus(1'b1, 1'b1, 1'b1);
        expect_st(2'd3, 1'b0, 1'b0, "R5 en133 high gives PCIX133");
        drive_bus(1'b1, 1'b1, 1'b0);
        expect_st(2'd2, 1'b0, 1'b0, "R5 en133 low gives PCIX100");

        // R2: strap capture
        pg_cycle(1'b1, 1'b0, 1'b0);
        expect_st(2'd2, 1'b1, 1'b0, "R2 strap 1 selects differential clock");

        // R3: strap and hot-plug changes between edges ignored
        @(negedge clk);
        strap_in = 1'b0; hp_en_in = 1'b1;
        settle(6);
        expect_st(2'd2, 1'b1, 1'b0, "R3 strap/hp change without pg edge ignored");
        @(negedge clk); hp_en_in = 1'b0;
        pg_cycle(1'b0, 1'b0, 1'b0);
        expect_st(2'd2, 1'b0, 1'b0, "R2 strap 0 selects 66 MHz clock");

        // R11: three-edge latency
        @(negedge clk);
        en133_in = 1'b1;
        settle(2);
        expect_st(2'd2, 1'b0, 1'b0, "R11 old mode after two edges");
        settle(1);
        expect_st(2'd3, 1'b0, 1'b0, "R11 new mode after third edge");

        // R6: hot-plug capture drives pin, forces PCI33
        pg_cycle(1'b0, 1'b1, 1'b0);
        expect_st(2'd0, 1'b0, 1'b1, "R6 hot-plug drives pin, PCI33 (R10 do low)");
        @(negedge clk); hp_en_in = 1'b0;
        settle(6);
        expect_st(2'd0, 1'b0, 1'b1, "R3 hp input drop without pg edge ignored");
        pg_cycle(1'b0, 1'b0, 1'b0);
        expect_st(2'd3, 1'b0, 1'b0, "R8 hot-plug cleared releases pin");

        // R9: no-glue keeps pin released even with hot-plug and slow write
        pg_cycle(1'b0, 1'b1, 1'b1);
        expect_st(2'd3, 1'b0, 1'b0, "R9 no-glue releases pin despite hot-plug");
        reg_write(2'b00);
        expect_st(2'd3, 1'b0, 1'b0, "R9 no-glue releases pin despite slow write");

        // R7: sticky record shows once no-glue is gone
        pg_cycle(1'b1, 1'b0, 1'b0);
        expect_st(2'd0, 1'b1, 1'b1, "R7 sticky slow write drives pin");
        reg_write(2'b01);
        expect_st(2'd0, 1'b1, 1'b1, "R7 later write 01 does not clear");
        reg_write(2'b10);
        expect_st(2'd0, 1'b1, 1'b1, "R7 later write 10 does not clear");

        // R1: mid-run reset clears record and captured strap
        @(negedge clk); rst = 1'b1; strap_in = 1'b0;
        settle(2);
        expect_st(2'd0, 1'b0, 1'b0, "R1 reset clears sticky and select");
        @(negedge clk); rst = 1'b0;
        settle(6);
        expect_st(2'd3, 1'b0, 1'b0, "R7 record stays clear after reset");

        // R8: non-slow write leaves pin released
        reg_write(2'b11);
        expect_st(2'd3, 1'b0, 1'b0, "R8 write 11 keeps pin released");
        drive_bus(1'b1, 1'b0, 1'b0);
        expect_st(2'd1, 1'b0, 1'b0, "R4 back to PCI66");

        // R7: direct slow write without any pg cycle
        reg_write(2'b00);
        expect_st(2'd0, 1'b0, 1'b1, "R7 slow write drives pin, PCI33");

        settle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule